// File: doc/BRIEF.md
# SDRAM Command Decoder and Device State Tracker

This block watches the control pins of an SDRAM interface on every rising clock edge and reports the single command that edge carries. The clock-enable level from the previous edge and the current one are both taken into account, so one pin pattern can resolve to auto refresh, self-refresh entry or deep power-down entry. Power-down entry and exit, and the exits from the low-power modes, are recognised from clock-enable transitions alone.

Alongside the decode, the block keeps a device-level model: which banks have an open row, which power mode the device is in, and whether the device still needs its initialization sequence. Every command is checked against that model. A command that is not allowed in the current state raises an illegal flag and leaves the model untouched. The block is intended as the front end of a protocol checker or a behavioural memory model, and it is placed next to the memory pins.

All outputs are registered. The result for the pins sampled at an edge is visible right after that edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Reset is active-low and synchronous. While reset is low, and right after it, the outputs are: cmd_o=0 (deselect), no bank open, power state 0 (normal), init_pending_o=1, illegal_o=0 and data_en_o=0. The stored previous clock-enable is cleared, so the first edge after reset decodes as deselect whatever the pins show.
- R2: In normal power state, with the previous clock-enable high, the pattern {cs_n,ras_n,cas_n,we_n} decodes as follows. 0011 is activate (2). 0101 is read (3). 0100 is write (4). 0010 is precharge (5 or 6). 0000 is mode register set (7). 0111 with cke high is no-op (1). cs_n=1 with cke high is deselect (0). With the previous clock-enable low, the decode is deselect.
- R3: For read and write, auto_pre_o equals a10. Precharge with a10=1 decodes as precharge-all (6) and ignores ba. Precharge with a10=0 decodes as 5 and acts on bank ba only.
- R4: Pattern 0001 decodes as auto refresh (8) when cke stays high, and as self-refresh entry (9) when cke falls. Either one is illegal while any bank is open. Self-refresh entry moves the power state to 2.
- R5: Pattern 0110 with cke falling is deep power-down entry (13). It is legal only when all banks are idle and no initialization is pending, and it moves the power state to 3. The same pattern with cke high decodes as undefined (15) and is illegal.
- R6: A no-op or deselect while cke falls is power-down entry (11). It moves the power state to 1, including with banks open. It is illegal while burst_active is high or while initialization is pending.
- R7: In power states 1, 2 and 3, cs_n, ras_n, cas_n and we_n are ignored. With cke low the decode is deselect and nothing changes. With cke high the decode is power-down exit (12), self-refresh exit (10) or deep power-down exit (14) respectively, and the power state returns to 0.
- R8: init_pending_o is set by reset and by deep power-down exit. While it is set, activate, read, write, single-bank precharge, self-refresh entry, power-down entry and deep power-down entry are illegal. Precharge-all, auto refresh, no-op and deselect are allowed. A legal mode register set clears the flag.
- R9: data_en_o is high exactly when the edge was in normal power state, the previous clock-enable was high and dqm was low.
- R10: A legal activate opens bank ba. A legal precharge closes bank ba. Precharge-all closes every bank. A legal read or write with a10=1 closes bank ba.
- R11: Activate to an open bank is illegal. Read or write to an idle bank is illegal. Mode register set or auto refresh while any bank is open is illegal.
- R12: An edge flagged illegal leaves bank_open_o, pwr_state_o and init_pending_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge samples the pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask, high masks |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-banks select) |
| ba | input | BANK_W | Bank select |
| burst_active | input | 1 | High while a data burst is in progress |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | BANK_W | Bank sampled with the command |
| auto_pre_o | output | 1 | Read or write with auto-precharge |
| illegal_o | output | 1 | Command not allowed in the current state |
| data_en_o | output | 1 | Data enable for this edge |
| bank_open_o | output | NUM_BANKS | Per-bank open-row status |
| pwr_state_o | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 deep power-down |
| init_pending_o | output | 1 | Initialization sequence still required |

## Verification
The bench builds the block with its default of four banks and therefore a two-bit bank select. With that setting, every bank index, all sixteen control pin patterns and all four pairs of old and new clock-enable can be reached within a few thousand cycles. A directed pass walks each power mode through entry, ignored pins and exit, and drives the initialization lockout and the bank conflicts. A long pseudo-random sweep then compares every output on every edge against an arithmetic model of the requirements. The sweep re-enters deep power-down and reinitializes many times.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

   typedef enum logic [3:0] {
      CMD_DESEL    = 4'd0,
      CMD_NOP      = 4'd1,
      CMD_ACT      = 4'd2,
      CMD_RD       = 4'd3,
      CMD_WR       = 4'd4,
      CMD_PRE      = 4'd5,
      CMD_PREA     = 4'd6,
      CMD_MRS      = 4'd7,
      CMD_AREF     = 4'd8,
      CMD_SREF_IN  = 4'd9,
      CMD_SREF_OUT = 4'd10,
      CMD_PDN_IN   = 4'd11,
      CMD_PDN_OUT  = 4'd12,
      CMD_DPD_IN   = 4'd13,
      CMD_DPD_OUT  = 4'd14,
      CMD_UNDEF    = 4'd15
   } sd_cmd_e;

   typedef enum logic [1:0] {
      PW_ON   = 2'd0,
      PW_PDN  = 2'd1,
      PW_SREF = 2'd2,
      PW_DPD  = 2'd3
   } sd_pwr_e;

endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic    cke_prev_i,
   input  logic    cke_i,
   input  logic    cs_n_i,
   input  logic    ras_n_i,
   input  logic    cas_n_i,
   input  logic    we_n_i,
   input  logic    a10_i,
   input  sd_pwr_e pwr_i,
   output sd_cmd_e cmd_o
);

   logic [2:0] strobes;
   assign strobes = {ras_n_i, cas_n_i, we_n_i};

   always_comb begin
      cmd_o = CMD_DESEL;
      if (pwr_i != PW_ON) begin
         // low-power modes: only a rising clock enable means anything
         if (cke_i) begin
            case (pwr_i)
               PW_PDN:  cmd_o = CMD_PDN_OUT;
               PW_SREF: cmd_o = CMD_SREF_OUT;
               default: cmd_o = CMD_DPD_OUT;
            endcase
         end
      end else if (!cke_prev_i) begin
         cmd_o = CMD_DESEL;
      end else if (cs_n_i) begin
         cmd_o = cke_i ? CMD_DESEL : CMD_PDN_IN;
      end else begin
         case (strobes)
            3'b111:  cmd_o = cke_i ? CMD_NOP : CMD_PDN_IN;
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
            3'b000:  cmd_o = CMD_MRS;
            3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF_IN;
            default: cmd_o = cke_i ? CMD_UNDEF : CMD_DPD_IN;
         endcase
      end
   end

endmodule

// File: rtl/sdcmd_bank_track.sv
`timescale 1ns/1ps
module sdcmd_bank_track
   import sdcmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 apply_i,
   input  sd_cmd_e              cmd_i,
   input  logic [BANK_W-1:0]    ba_i,
   input  logic                 a10_i,
   output logic [NUM_BANKS-1:0] open_o,
   output logic                 hit_o,
   output logic                 any_o
);

   logic [NUM_BANKS-1:0] open_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel;
      assign sel = (ba_i == BANK_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q[b] <= 1'b0;
         end else if (apply_i) begin
            case (cmd_i)
               CMD_ACT:        if (sel) open_q[b] <= 1'b1;
               CMD_PRE:        if (sel) open_q[b] <= 1'b0;
               CMD_PREA:       open_q[b] <= 1'b0;
               CMD_RD, CMD_WR: if (sel && a10_i) open_q[b] <= 1'b0;
               default:        ;
            endcase
         end
      end
   end

   assign open_o = open_q;
   assign hit_o  = open_q[ba_i];
   assign any_o  = |open_q;

   // R10
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_i && cmd_i == CMD_ACT) |=> open_q[$past(ba_i)]);

   // R12
   held_when_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !apply_i |=> open_q == $past(open_q));

endmodule

// File: rtl/sdcmd_state_ctl.sv
`timescale 1ns/1ps
module sdcmd_state_ctl
   import sdcmd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  sd_cmd_e cmd_i,
   input  logic    hit_i,
   input  logic    any_open_i,
   input  logic    burst_i,
   output logic    illegal_o,
   output sd_pwr_e pwr_o,
   output logic    init_o
);

   sd_pwr_e pwr_q;
   logic    init_q;
   logic    ill;

   always_comb begin
      case (cmd_i)
         CMD_ACT:                 ill = init_q | hit_i;
         CMD_RD, CMD_WR:          ill = init_q | ~hit_i;
         CMD_PRE:                 ill = init_q;
         CMD_MRS, CMD_AREF:       ill = any_open_i;
         CMD_SREF_IN, CMD_DPD_IN: ill = init_q | any_open_i;
         CMD_PDN_IN:              ill = init_q | burst_i;
         CMD_UNDEF:               ill = 1'b1;
         default:                 ill = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q  <= PW_ON;
         init_q <= 1'b1;
      end else if (!ill) begin
         case (cmd_i)
            CMD_SREF_IN:               pwr_q <= PW_SREF;
            CMD_PDN_IN:                pwr_q <= PW_PDN;
            CMD_DPD_IN:                pwr_q <= PW_DPD;
            CMD_SREF_OUT, CMD_PDN_OUT: pwr_q <= PW_ON;
            CMD_DPD_OUT: begin
               pwr_q  <= PW_ON;
               init_q <= 1'b1;
            end
            CMD_MRS:                   init_q <= 1'b0;
            default:                   ;
         endcase
      end
   end

   assign illegal_o = ill;
   assign pwr_o     = pwr_q;
   assign init_o    = init_q;

   // R8
   init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_q) |-> $past(cmd_i == CMD_MRS));

   // R7
   dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q == PW_DPD && cmd_i == CMD_DPD_OUT) |=> (pwr_q == PW_ON && init_q));

   // R4
   sref_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_q == PW_SREF) |-> !any_open_i);

endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker
   import sdcmd_pkg::*;
#(
   parameter  int NUM_BANKS = 4,
   localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 dqm,
   input  logic                 a10,
   input  logic [BANK_W-1:0]    ba,
   input  logic                 burst_active,
   output logic [3:0]           cmd_o,
   output logic [BANK_W-1:0]    bank_o,
   output logic                 auto_pre_o,
   output logic                 illegal_o,
   output logic                 data_en_o,
   output logic [NUM_BANKS-1:0] bank_open_o,
   output logic [1:0]           pwr_state_o,
   output logic                 init_pending_o
);

   if (NUM_BANKS < 2) begin : g_bad_count
      $error("sdram_cmd_tracker: NUM_BANKS must be at least 2");
   end
   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_pow2
      $error("sdram_cmd_tracker: NUM_BANKS must be a power of two");
   end

   logic                 cke_prev_q;
   sd_cmd_e              cmd_now;
   sd_pwr_e              pwr;
   logic                 ill_now;
   logic                 hit;
   logic                 any_open;
   logic [NUM_BANKS-1:0] open_vec;
   logic                 init_flag;

   sdcmd_decode u_decode (
      .cke_prev_i (cke_prev_q),
      .cke_i      (cke),
      .cs_n_i     (cs_n),
      .ras_n_i    (ras_n),
      .cas_n_i    (cas_n),
      .we_n_i     (we_n),
      .a10_i      (a10),
      .pwr_i      (pwr),
      .cmd_o      (cmd_now)
   );

   sdcmd_state_ctl u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd_now),
      .hit_i      (hit),
      .any_open_i (any_open),
      .burst_i    (burst_active),
      .illegal_o  (ill_now),
      .pwr_o      (pwr),
      .init_o     (init_flag)
   );

   sdcmd_bank_track #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply_i (!ill_now),
      .cmd_i   (cmd_now),
      .ba_i    (ba),
      .a10_i   (a10),
      .open_o  (open_vec),
      .hit_o   (hit),
      .any_o   (any_open)
   );

   sd_cmd_e           cmd_q;
   logic [BANK_W-1:0] bank_q;
   logic              ap_q;
   logic              ill_q;
   logic              den_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_prev_q <= 1'b0;
         cmd_q      <= CMD_DESEL;
         bank_q     <= '0;
         ap_q       <= 1'b0;
         ill_q      <= 1'b0;
         den_q      <= 1'b0;
      end else begin
         cke_prev_q <= cke;
         cmd_q      <= cmd_now;
         bank_q     <= ba;
         ap_q       <= ((cmd_now == CMD_RD) || (cmd_now == CMD_WR)) && a10;
         ill_q      <= ill_now;
         den_q      <= (pwr == PW_ON) && cke_prev_q && !dqm;
      end
   end

   assign cmd_o          = cmd_q;
   assign bank_o         = bank_q;
   assign auto_pre_o     = ap_q;
   assign illegal_o      = ill_q;
   assign data_en_o      = den_q;
   assign bank_open_o    = open_vec;
   assign pwr_state_o    = pwr;
   assign init_pending_o = init_flag;

   // R12
   illegal_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (bank_open_o == $past(bank_open_o) &&
                     pwr_state_o == $past(pwr_state_o) &&
                     init_pending_o == $past(init_pending_o)));

   // R9
   den_lowpower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwr_state_o) != 2'd0) |-> !data_en_o);

endmodule

// File: tb/sdram_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_bench;

   localparam logic [3:0] P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                          P_PRE = 4'b0010, P_MRS = 4'b0000, P_NOP = 4'b0111,
                          P_DES = 4'b1111, P_REF = 4'b0001, P_DPD = 4'b0110;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic       dqm = 1'b1, a10 = 1'b0, burst_active = 1'b0;
   logic [1:0] ba = 2'd0;
   logic [3:0] cmd_o;
   logic [1:0] bank_o;
   logic       auto_pre_o, illegal_o, data_en_o, init_pending_o;
   logic [3:0] bank_open_o;
   logic [1:0] pwr_state_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench-side state model
   bit [3:0] m_banks;
   int       m_pwr;
   bit       m_init;
   bit       m_ckep;
   int       e_cmd;
   bit       e_ill, e_den, e_ap;

   always #2.5 clk = ~clk;

   sdram_cmd_tracker #(.NUM_BANKS(4)) u_sdram_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .a10(a10), .ba(ba),
      .burst_active(burst_active), .cmd_o(cmd_o), .bank_o(bank_o),
      .auto_pre_o(auto_pre_o), .illegal_o(illegal_o), .data_en_o(data_en_o),
      .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o),
      .init_pending_o(init_pending_o)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_banks = '0; m_pwr = 0; m_init = 1; m_ckep = 0;
   endtask

   task automatic predict(input bit k, input bit [3:0] p, input bit a, input bit [1:0] b,
                          input bit bu, input bit dm);
      int c; bit il; bit anyo; bit hit;
      if (m_pwr != 0) c = k ? ((m_pwr == 1) ? 12 : ((m_pwr == 2) ? 10 : 14)) : 0;
      else if (!m_ckep) c = 0;
      else if (p[3]) c = k ? 0 : 11;
      else begin
         case (p[2:0])
            3'b111:  c = k ? 1 : 11;
            3'b011:  c = 2;
            3'b101:  c = 3;
            3'b100:  c = 4;
            3'b010:  c = a ? 6 : 5;
            3'b000:  c = 7;
            3'b001:  c = k ? 8 : 9;
            default: c = k ? 15 : 13;
         endcase
      end
      anyo = |m_banks;
      hit  = m_banks[b];
      case (c)
         2:     il = m_init || hit;
         3, 4:  il = m_init || !hit;
         5:     il = m_init;
         7, 8:  il = anyo;
         9, 13: il = m_init || anyo;
         11:    il = m_init || bu;
         15:    il = 1;
         default: il = 0;
      endcase
      e_cmd = c; e_ill = il;
      e_den = (m_pwr == 0) && m_ckep && !dm;
      e_ap  = ((c == 3) || (c == 4)) && a;
      if (!il) begin
         case (c)
            2:     m_banks[b] = 1'b1;
            5:     m_banks[b] = 1'b0;
            6:     m_banks = '0;
            3, 4:  if (a) m_banks[b] = 1'b0;
            7:     m_init = 0;
            9:     m_pwr = 2;
            11:    m_pwr = 1;
            13:    m_pwr = 3;
            10, 12: m_pwr = 0;
            14: begin m_pwr = 0; m_init = 1; end
            default: ;
         endcase
      end
      m_ckep = k;
   endtask

   task automatic step(input string tag, input bit k, input bit [3:0] p, input bit a,
                       input bit [1:0] b, input bit bu, input bit dm);
      cke = k; {cs_n, ras_n, cas_n, we_n} = p; a10 = a; ba = b;
      burst_active = bu; dqm = dm;
      predict(k, p, a, b, bu, dm);
      @(posedge clk); #1;
      chk(tag, "cmd_o", int'(cmd_o), e_cmd);
      chk(tag, "illegal_o", int'(illegal_o), int'(e_ill));
      chk(tag, "bank_open_o", int'(bank_open_o), int'(m_banks));
      chk(tag, "pwr_state_o", int'(pwr_state_o), m_pwr);
      chk(tag, "init_pending_o", int'(init_pending_o), int'(m_init));
      chk(tag, "data_en_o", int'(data_en_o), int'(e_den));
      chk(tag, "auto_pre_o", int'(auto_pre_o), int'(e_ap));
      chk(tag, "bank_o", int'(bank_o), int'(b));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit [31:0] lcg;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "cmd_o", int'(cmd_o), 0);
      chk("R1", "bank_open_o", int'(bank_open_o), 0);
      chk("R1", "pwr_state_o", int'(pwr_state_o), 0);
      chk("R1", "init_pending_o", int'(init_pending_o), 1);
      chk("R1", "illegal_o", int'(illegal_o), 0);
      chk("R1", "data_en_o", int'(data_en_o), 0);
      rst_n = 1'b1;
      model_reset();
      step("R1", 1, P_ACT, 0, 2'd0, 0, 0);     // previous cke cleared: deselect
      // R8 initialization lockout
      step("R8", 1, P_ACT, 0, 2'd0, 0, 0);
      step("R8", 1, P_RD,  0, 2'd0, 0, 0);
      step("R8", 1, P_PRE, 0, 2'd1, 0, 0);
      step("R8", 1, P_PRE, 1, 2'd1, 0, 0);
      step("R8", 1, P_REF, 0, 2'd0, 0, 0);
      step("R8", 1, P_NOP, 0, 2'd0, 0, 0);
      step("R8", 1, P_MRS, 0, 2'd0, 0, 0);
      // R2 and R10: open every bank
      for (int b = 0; b < 4; b++) step("R10", 1, P_ACT, 0, 2'(b), 0, 0);
      step("R11", 1, P_ACT, 0, 2'd0, 0, 0);
      step("R3",  1, P_RD,  0, 2'd1, 0, 0);
      step("R3",  1, P_WR,  1, 2'd2, 0, 0);
      step("R11", 1, P_RD,  0, 2'd2, 0, 0);
      step("R11", 1, P_MRS, 0, 2'd0, 0, 0);
      step("R4",  1, P_REF, 0, 2'd0, 0, 0);
      step("R4",  0, P_REF, 0, 2'd0, 0, 0);
      step("R2",  1, P_DES, 0, 2'd0, 0, 0);
      step("R3",  1, P_PRE, 0, 2'd0, 0, 0);
      step("R3",  1, P_PRE, 1, 2'd3, 0, 0);
      // R9 data enable
      step("R9", 1, P_NOP, 0, 2'd0, 0, 0);
      step("R9", 1, P_NOP, 0, 2'd0, 0, 1);
      // R6 power-down entry
      step("R6", 0, P_NOP, 0, 2'd0, 1, 0);
      step("R6", 1, P_DES, 0, 2'd0, 0, 0);
      step("R6", 0, P_NOP, 0, 2'd0, 0, 0);
      step("R7", 0, P_ACT, 0, 2'd2, 0, 0);
      step("R7", 1, P_ACT, 0, 2'd2, 0, 0);
      step("R6", 1, P_ACT, 0, 2'd1, 0, 0);
      step("R6", 0, P_DES, 0, 2'd0, 0, 0);
      step("R7", 1, P_DES, 0, 2'd0, 0, 0);
      step("R6", 1, P_PRE, 1, 2'd0, 0, 0);
      // R4 refresh and self refresh
      step("R4", 1, P_REF, 0, 2'd0, 0, 0);
      step("R4", 0, P_REF, 0, 2'd0, 0, 0);
      step("R7", 0, P_MRS, 0, 2'd0, 0, 0);
      step("R7", 1, P_NOP, 0, 2'd0, 0, 0);
      // R5 deep power-down
      step("R5", 1, P_DPD, 0, 2'd0, 0, 0);
      step("R5", 1, P_ACT, 0, 2'd1, 0, 0);
      step("R5", 0, P_DPD, 0, 2'd0, 0, 0);
      step("R5", 1, P_DES, 0, 2'd0, 0, 0);
      step("R5", 1, P_PRE, 1, 2'd0, 0, 0);
      step("R5", 0, P_DPD, 0, 2'd0, 0, 0);
      step("R7", 0, P_NOP, 0, 2'd0, 0, 0);
      step("R7", 1, P_NOP, 0, 2'd0, 0, 0);
      step("R8", 1, P_ACT, 0, 2'd0, 0, 0);
      step("R8", 1, P_MRS, 0, 2'd0, 0, 0);
      // R12 and R2: pseudo-random sweep over all inputs
      lcg = 32'h1234_5678;
      for (int i = 0; i < 6000; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         step("R12", lcg[31:30] != 2'b00, lcg[27:24], lcg[23], lcg[21:20],
              lcg[19:17] == 3'b000, lcg[16]);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule